// File: doc/BRIEF.md
# Local Inject/Eject Stage for a Bufferless Deflection Router

This block is the pipeline stage that a bufferless deflection router runs ahead of its permutation network. Each cycle it receives up to four flits from the incoming links. It takes out at most one flit addressed to this node and sends it toward local reassembly storage. It then fills one empty slot with a new flit from the local injection queue. The four resulting slots and the ejected flit are registered and handed to the routing stage one cycle later.

When several flits for this node arrive together, one that belongs to the currently golden packet is served first. The golden packet identity is an input to this stage. Flits that lose this contest stay in their slots and are deflected by the routing stage.

New traffic never takes a slot that holds a flit already in flight. It has the lowest priority and enters only where a slot is empty after ejection. This includes a slot that ejection freed in the same cycle.

Top module: `ie_local_stage`

## Requirements
- R1: While `rst_n` is low, every output slot and `eject_flit` read as all zero and `inj_pop` is 0.
- R2: A flit is a 52-bit word. From most to least significant it holds: valid (bit 51), destination x (50:48), destination y (47:45), source id (44:39), request id (38:35), sequence (34:32) and data (31:0). Slot j of a port bus is bits [52*j+51 : 52*j]. A valid flit whose destination differs from (`my_x`,`my_y`) appears unchanged in the same slot of `route_out` one clock edge later.
- R3: A valid flit whose destination equals (`my_x`,`my_y`) is a local flit. When any local flit is present, exactly one of them appears on `eject_flit` one edge later and is removed from its slot. Otherwise `eject_flit` is all zero.
- R4: A local flit is golden when its source id equals `gold_src` and its request id equals `gold_req`. If any local flit is golden, a golden one is ejected.
- R5: Among local flits of equal standing (all golden or all non-golden), the lowest-numbered slot ejects.
- R6: Local flits that are not ejected stay in their own slot of `route_out` unchanged.
- R7: When `inj_avail` is 1 and a slot is empty after ejection, `inj_flit` is placed, with its valid bit forced to 1, into the lowest-numbered such slot one edge later. `inj_pop` is 1 in exactly the cycles in which this happens.
- R8: When all four slots stay occupied after ejection, `inj_pop` is 0 and every in-flight flit passes through. Injection never displaces a flit.
- R9: A slot vacated by ejection in a cycle counts as empty for injection in that same cycle.
- R10: An output slot that holds no flit reads as all zero, whatever the other bits of an invalid input slot carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | 3 | This node's x coordinate |
| my_y | input | 3 | This node's y coordinate |
| gold_src | input | 6 | Source id of the golden packet |
| gold_req | input | 4 | Request id of the golden packet |
| link_in | input | 208 | Four incoming link flits, slot j at [52*j +: 52] |
| inj_avail | input | 1 | Injection queue holds a flit |
| inj_flit | input | 52 | Head of the injection queue |
| inj_pop | output | 1 | Head flit accepted this cycle; queue pops on the edge |
| route_out | output | 208 | Registered four slots toward the routing stage |
| eject_flit | output | 52 | Registered ejected flit toward reassembly storage |

## Verification
Ejection and injection can happen in the same cycle. A full set of four valid inputs with one or more local flits and a waiting injection flit brings this about. The bench checks that the injected flit lands in exactly the slot that was just vacated, that `inj_pop` rises in that cycle, and that the other slots are undisturbed. It also checks cases where only one of the two functions can act: all slots carry transit flits, or there is no local flit but there is a hole. In these cases the bench confirms that the other function leaves the slots alone.

// File: rtl/ie_pkg.sv
package ie_pkg;
    localparam int PORTS = 4;
    localparam int XW    = 3;
    localparam int YW    = 3;
    localparam int NW    = 6;
    localparam int RQW   = 4;
    localparam int SQW   = 3;
    localparam int DW    = 32;
    localparam int IW    = $clog2(PORTS);

    typedef struct packed {
        logic           vld;
        logic [XW-1:0]  dx;
        logic [YW-1:0]  dy;
        logic [NW-1:0]  src;
        logic [RQW-1:0] req;
        logic [SQW-1:0] seq;
        logic [DW-1:0]  data;
    } flit_t;

    localparam int FW = $bits(flit_t);
endpackage

// File: rtl/ie_eject_sel.sv
module ie_eject_sel
    import ie_pkg::*;
(
    input  flit_t          slots [PORTS],
    input  logic [XW-1:0]  my_x,
    input  logic [YW-1:0]  my_y,
    input  logic [NW-1:0]  gold_src,
    input  logic [RQW-1:0] gold_req,
    output logic           sel_vld,
    output logic [IW-1:0]  sel_idx
);
    logic [PORTS-1:0] is_local;
    logic [PORTS-1:0] is_gold;

    for (genvar g = 0; g < PORTS; g++) begin : g_flag
        assign is_local[g] = slots[g].vld && (slots[g].dx == my_x) && (slots[g].dy == my_y);
        assign is_gold[g]  = is_local[g] && (slots[g].src == gold_src) && (slots[g].req == gold_req);
    end

    always_comb begin
        logic [PORTS-1:0] pool;
        pool    = (|is_gold) ? is_gold : is_local;
        sel_vld = |pool;
        sel_idx = '0;
        for (int i = PORTS - 1; i >= 0; i--) begin
            if (pool[i]) sel_idx = IW'(i);
        end
    end
endmodule

// File: rtl/ie_inject_fill.sv
module ie_inject_fill
    import ie_pkg::*;
(
    input  logic [PORTS-1:0] occupied,
    input  logic             inj_avail,
    output logic             fill_vld,
    output logic [IW-1:0]    fill_idx
);
    always_comb begin
        fill_vld = inj_avail && !(&occupied);
        fill_idx = '0;
        for (int i = PORTS - 1; i >= 0; i--) begin
            if (!occupied[i]) fill_idx = IW'(i);
        end
    end
endmodule

// File: rtl/ie_local_stage.sv
module ie_local_stage
    import ie_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XW-1:0]       my_x,
    input  logic [YW-1:0]       my_y,
    input  logic [NW-1:0]       gold_src,
    input  logic [RQW-1:0]      gold_req,
    input  logic [PORTS*FW-1:0] link_in,
    input  logic                inj_avail,
    input  logic [FW-1:0]       inj_flit,
    output logic                inj_pop,
    output logic [PORTS*FW-1:0] route_out,
    output logic [FW-1:0]       eject_flit
);
    flit_t            in_slot  [PORTS];
    flit_t            nxt_slot [PORTS];
    flit_t            slot_q   [PORTS];
    flit_t            nxt_ej;
    flit_t            ej_q;
    flit_t            inj_f;
    logic             ej_vld;
    logic [IW-1:0]    ej_idx;
    logic [PORTS-1:0] occ_after;
    logic             fill_vld;
    logic [IW-1:0]    fill_idx;

    assign inj_f = flit_t'(inj_flit);

    for (genvar g = 0; g < PORTS; g++) begin : g_io
        assign in_slot[g]                 = link_in[g*FW +: FW];
        assign route_out[g*FW +: FW]      = slot_q[g];
        assign occ_after[g]               = in_slot[g].vld && !(ej_vld && (ej_idx == IW'(g)));
    end
    assign eject_flit = ej_q;

    ie_eject_sel u_ej (
        .slots    (in_slot),
        .my_x     (my_x),
        .my_y     (my_y),
        .gold_src (gold_src),
        .gold_req (gold_req),
        .sel_vld  (ej_vld),
        .sel_idx  (ej_idx)
    );

    ie_inject_fill u_inj (
        .occupied (occ_after),
        .inj_avail(inj_avail),
        .fill_vld (fill_vld),
        .fill_idx (fill_idx)
    );

    assign inj_pop = rst_n && fill_vld;

    always_comb begin
        nxt_ej = ej_vld ? in_slot[ej_idx] : '0;
        for (int i = 0; i < PORTS; i++) begin
            if (fill_vld && (fill_idx == IW'(i))) begin
                nxt_slot[i]     = inj_f;
                nxt_slot[i].vld = 1'b1;
            end else if (occ_after[i]) begin
                nxt_slot[i] = in_slot[i];
            end else begin
                nxt_slot[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ej_q <= '0;
            for (int i = 0; i < PORTS; i++) slot_q[i] <= '0;
        end else begin
            ej_q <= nxt_ej;
            for (int i = 0; i < PORTS; i++) slot_q[i] <= nxt_slot[i];
        end
    end
endmodule

// File: rtl/ie_local_stage_chk.sv
module ie_local_stage_chk
    import ie_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [XW-1:0]       my_x,
    input logic [YW-1:0]       my_y,
    input logic [NW-1:0]       gold_src,
    input logic [RQW-1:0]      gold_req,
    input logic [PORTS*FW-1:0] link_in,
    input logic                inj_avail,
    input logic [FW-1:0]       inj_flit,
    input logic                inj_pop,
    input logic [PORTS*FW-1:0] route_out,
    input logic [FW-1:0]       eject_flit
);
    flit_t ejc;
    logic  gold_here;
    logic  all_busy;
    int    cnt_in;
    int    cnt_out;

    assign ejc = flit_t'(eject_flit);

    always_comb begin
        flit_t f;
        logic  any_local;
        gold_here = 1'b0;
        any_local = 1'b0;
        cnt_in    = 0;
        cnt_out   = 0;
        for (int i = 0; i < PORTS; i++) begin
            f = flit_t'(link_in[i*FW +: FW]);
            if (f.vld) cnt_in++;
            if (f.vld && f.dx == my_x && f.dy == my_y) begin
                any_local = 1'b1;
                if (f.src == gold_src && f.req == gold_req) gold_here = 1'b1;
            end
            f = flit_t'(route_out[i*FW +: FW]);
            if (f.vld) cnt_out++;
        end
        all_busy = (cnt_in == PORTS) && !any_local;
        if (inj_pop) cnt_in++;
        if (any_local) cnt_in--;
        if (ejc.vld) cnt_out++;
    end

    AST_POP_NEEDS_FLIT: assert property (@(posedge clk) disable iff (!rst_n) inj_pop |-> inj_avail); // R7
    AST_NO_POP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) all_busy |-> !inj_pop); // R8
    AST_EJECT_IS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        ejc.vld |-> (ejc.dx == $past(my_x) && ejc.dy == $past(my_y))); // R3
    AST_GOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        gold_here |=> (ejc.vld && ejc.src == $past(gold_src) && ejc.req == $past(gold_req))); // R4
    AST_FLIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_out == $past(cnt_in) + (ejc.vld ? 1 : 0))); // R6
endmodule

bind ie_local_stage ie_local_stage_chk u_chk (.*);

// File: tb/sim_ie_local_stage.sv
`timescale 1ns/1ps
module sim_ie_local_stage;
    localparam int FW = 52;
    localparam int NV = 12;
    // entry: codes slot3..slot0 (2b each: 0 empty,1 transit,2 local,3 local golden), avail, exp_ej(3b), exp_inj(3b); 4 = none
    localparam logic [14:0] VEC [NV] = '{
        {2'd1,2'd1,2'd1,2'd1, 1'b1, 3'd4, 3'd4},
        {2'd1,2'd1,2'd1,2'd0, 1'b1, 3'd4, 3'd0},
        {2'd1,2'd0,2'd0,2'd1, 1'b1, 3'd4, 3'd1},
        {2'd1,2'd1,2'd1,2'd2, 1'b1, 3'd0, 3'd0},
        {2'd1,2'd2,2'd2,2'd1, 1'b0, 3'd1, 3'd4},
        {2'd1,2'd3,2'd2,2'd2, 1'b0, 3'd2, 3'd4},
        {2'd2,2'd3,2'd1,2'd3, 1'b1, 3'd0, 3'd0},
        {2'd0,2'd0,2'd0,2'd0, 1'b0, 3'd4, 3'd4},
        {2'd0,2'd0,2'd0,2'd0, 1'b1, 3'd4, 3'd0},
        {2'd2,2'd2,2'd2,2'd2, 1'b1, 3'd0, 3'd0},
        {2'd2,2'd1,2'd1,2'd1, 1'b1, 3'd3, 3'd3},
        {2'd2,2'd0,2'd3,2'd1, 1'b1, 3'd1, 3'd1}
    };

    logic           clk = 0;
    logic           rst_n = 0;
    logic [2:0]     my_x = 3'd3, my_y = 3'd5;
    logic [5:0]     gold_src = 6'd9;
    logic [3:0]     gold_req = 4'd4;
    logic [4*FW-1:0] link_in = '0;
    logic           inj_avail = 0;
    logic [FW-1:0]  inj_flit = '0;
    logic           inj_pop;
    logic [4*FW-1:0] route_out;
    logic [FW-1:0]  eject_flit;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ie_local_stage u0 (.*);

    function automatic string tag_of(int v);
        case (v)
            0: return "R8"; 1: return "R7"; 2: return "R7"; 3: return "R9";
            4: return "R5"; 5: return "R4"; 6: return "R4"; 7: return "R10";
            8: return "R7"; 9: return "R9"; 10: return "R3"; default: return "R6";
        endcase
    endfunction

    function automatic logic [FW-1:0] mk(logic [1:0] code, int v, int j);
        logic [2:0] dx, dy; logic [5:0] s; logic [3:0] r;
        if (code == 0) return {1'b0, 51'h0};
        dx = (code == 1) ? 3'd1 : 3'd3;
        dy = (code == 1) ? 3'd2 : 3'd5;
        s  = (code == 3) ? 6'd9 : 6'(20 + j);
        r  = 4'd4;
        return {1'b1, dx, dy, s, r, 3'(j), 32'(v * 16 + j + 1)};
    endfunction

    task automatic chk(string tag, logic [FW*4-1:0] act, logic [FW*4-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [4*FW-1:0] exp_r;
        logic [FW-1:0]   exp_e;
        // R1: reset with busy inputs
        link_in = {mk(2,0,3), mk(3,0,2), mk(2,0,1), mk(1,0,0)};
        inj_avail = 1; inj_flit = {1'b0, 3'd1, 3'd1, 6'd2, 4'd3, 3'd0, 32'hCAFE0001};
        repeat (3) @(posedge clk);
        #1;
        chk("R1 route", route_out, '0);
        chk("R1 eject", {156'h0, eject_flit}, '0);
        chk("R1 pop", {207'h0, inj_pop}, '0);
        @(negedge clk); rst_n = 1;

        for (int v = 0; v < NV; v++) begin
            logic [14:0] e;
            logic [FW-1:0] f [4];
            int ej, ij;
            e = VEC[v];
            @(negedge clk);
            for (int j = 0; j < 4; j++) f[j] = mk(e[7 + 2*j +: 2], v, j);
            link_in = {f[3], f[2], f[1], f[0]};
            inj_avail = e[6];
            inj_flit = {1'b0, 3'd0, 3'd7, 6'd1, 4'd2, 3'd0, 32'(32'hA000 + v)};
            ej = int'(e[5:3]); ij = int'(e[2:0]);
            #1;
            chk({tag_of(v), " pop"}, {207'h0, inj_pop}, {207'h0, (ij != 4)});
            exp_e = (ej != 4) ? f[ej] : '0;
            for (int j = 0; j < 4; j++) begin
                if (j == ij) exp_r[j*FW +: FW] = {1'b1, inj_flit[FW-2:0]};
                else if (j == ej || e[7 + 2*j +: 2] == 0) exp_r[j*FW +: FW] = '0;
                else exp_r[j*FW +: FW] = f[j];
            end
            @(posedge clk); #1;
            chk({tag_of(v), " route"}, route_out, exp_r);
            chk({tag_of(v), " eject"}, {156'h0, eject_flit}, {156'h0, exp_e});
        end

        // R10: invalid slot carrying junk must read as zero; R2 transit in other slots
        @(negedge clk);
        link_in = {mk(1,20,3), {1'b0, 51'h7_FFFF_FFFF_FFFF}, mk(1,20,1), {1'b0, 3'd3, 3'd5, 6'd9, 4'd4, 35'h1}};
        inj_avail = 0;
        @(posedge clk); #1;
        chk("R10 route", route_out, {mk(1,20,3), 52'h0, mk(1,20,1), 52'h0});
        chk("R10 eject", {156'h0, eject_flit}, '0);

        // R3: coordinates change, transit flits become local
        @(negedge clk);
        my_x = 3'd1; my_y = 3'd2;
        link_in = {mk(0,21,3), mk(1,21,2), mk(0,21,1), mk(0,21,0)};
        @(posedge clk); #1;
        chk("R3 eject", {156'h0, eject_flit}, {156'h0, mk(1,21,2)});
        chk("R3 route", route_out, '0);

        // R1: asynchronous reset mid-run
        @(negedge clk);
        link_in = {mk(1,22,3), mk(1,22,2), mk(1,22,1), mk(1,22,0)};
        @(posedge clk); #1;
        rst_n = 0; #1;
        chk("R1 async route", route_out, '0);
        chk("R1 async pop", {207'h0, inj_pop}, '0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule